// File: doc/BRIEF.md
# Halt-Initiated Suspend Controller

This block takes a processor core into a low-power suspend state after the core runs a halt instruction, and brings it back out when an interrupt arrives. The core pulses a halt strobe. If the suspend-on-halt enable bit from configuration is set, the controller asks the bus logic to run the halt bus cycle. It asserts the active-low suspend-acknowledge pin only after that cycle is done and no PCI master transfer is in flight.

While the core is suspended, a PCI master may still use the bus. The acknowledge pin is released for as long as that traffic lasts and is then taken low again. The block wakes on a maskable interrupt whose mask is clear, or on a low system management interrupt, which cannot be masked. The pin is normally released one clock after the wake is seen. A refresh cycle that is in progress holds the release back, up to a bounded number of clocks. A one-clock wake pulse goes to the core at the moment of exit.

Top module: `halt_suspend_ctl`

## Requirements
- R1: While reset is active and after it is released, sus_ack_n_o is 1, halt_cyc_req_o is 0 and wake_o is 0.
- R2: A halt strobe sampled while sus_en_i is 1 raises halt_cyc_req_o from the next clock. The request stays high until the clock after halt_cyc_done_i is sampled high. A halt strobe sampled while sus_en_i is 0 has no effect: the request stays 0 and sus_ack_n_o stays 1.
- R3: sus_ack_n_o goes low on the second clock edge after halt_cyc_done_i is sampled high, provided pci_busy_i is 0 at that edge.
- R4: If pci_busy_i is high after the halt bus cycle, sus_ack_n_o stays 1 until the first clock edge at which pci_busy_i is sampled 0. It goes low at that edge.
- R5: While suspended, pci_busy_i sampled high releases sus_ack_n_o (drives it to 1) from the next clock. If no wake is pending, sus_ack_n_o returns to 0 on the clock after pci_busy_i is sampled 0.
- R6: The wake condition is intr_i=1 with intr_mask_i=0, or smi_n_i=0. An interrupt with intr_mask_i=1 is ignored and the block stays suspended. When sus_ack_n_o is 0 and refresh_busy_i is 0, sus_ack_n_o rises on the clock after the wake condition is sampled. This is well within six clocks.
- R7: If refresh_busy_i is high when the wake is seen, sus_ack_n_o stays 0 until the clock after refresh_busy_i is sampled 0. It rises no later than REF_HOLD_MAX+1 clocks after the wake was sampled.
- R8: wake_o is a one-clock pulse. It is issued on the clock where suspend ends, with sus_ack_n_o at 1. The block is then idle and accepts a new halt.
- R9: A wake condition seen during the halt bus cycle, or while a PCI master window holds the pin released, is kept. The block leaves suspend as soon as that window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_strobe_i | input | 1 | One-clock pulse when the core executes a halt |
| sus_en_i | input | 1 | Suspend-on-halt enable from configuration |
| halt_cyc_done_i | input | 1 | Halt bus cycle completed |
| pci_busy_i | input | 1 | PCI master transfer in progress |
| refresh_busy_i | input | 1 | Memory refresh cycle in progress |
| intr_i | input | 1 | Maskable interrupt request |
| intr_mask_i | input | 1 | Interrupt mask, 1 = masked |
| smi_n_i | input | 1 | System management interrupt, active low |
| sus_ack_n_o | output | 1 | Suspend acknowledge, active low |
| halt_cyc_req_o | output | 1 | Request to run the halt bus cycle |
| wake_o | output | 1 | One-clock wake pulse to the core |

## Verification
The properties assume that halt_cyc_done_i arrives only while the halt cycle is being requested. They also assume that refresh_busy_i, once high, does not stay high forever, and that the inputs are synchronous to clk. The stimulus drives every input at the falling edge. It raises the done flag only in the cycles right after a request appears. It keeps refresh windows finite, including the one that tests the hold-back limit, so the fast-release and release-on-PCI properties see only legal input orderings.

// File: rtl/halt_suspend_ctl.sv
module halt_suspend_ctl #(
  parameter int REF_HOLD_MAX = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_strobe_i,
  input  logic sus_en_i,
  input  logic halt_cyc_done_i,
  input  logic pci_busy_i,
  input  logic refresh_busy_i,
  input  logic intr_i,
  input  logic intr_mask_i,
  input  logic smi_n_i,
  output logic sus_ack_n_o,
  output logic halt_cyc_req_o,
  output logic wake_o
);
  localparam int CW = $clog2(REF_HOLD_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_HCYC, S_DRAIN, S_SUSP, S_MSTR, S_RHOLD} st_t;

  st_t           st;
  logic          ack_q, wake_q, pend;
  logic [CW-1:0] rcnt;

  wire wake_cond = (intr_i & ~intr_mask_i) | ~smi_n_i;

  assign sus_ack_n_o    = ~ack_q;
  assign halt_cyc_req_o = (st == S_HCYC);
  assign wake_o         = wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ack_q  <= 1'b0;
      wake_q <= 1'b0;
      pend   <= 1'b0;
      rcnt   <= '0;
    end else begin
      wake_q <= 1'b0;
      case (st)
        S_IDLE: begin
          pend <= 1'b0;
          if (halt_strobe_i && sus_en_i) st <= S_HCYC;
        end
        S_HCYC: begin
          if (wake_cond) pend <= 1'b1;
          if (halt_cyc_done_i) st <= S_DRAIN;
        end
        S_DRAIN: begin
          if (wake_cond) pend <= 1'b1;
          if (!pci_busy_i) begin
            st    <= S_SUSP;
            ack_q <= 1'b1;
          end
        end
        S_SUSP: begin
          if (wake_cond || pend) begin
            if (refresh_busy_i) begin
              st   <= S_RHOLD;
              rcnt <= '0;
            end else begin
              st     <= S_IDLE;
              ack_q  <= 1'b0;
              wake_q <= 1'b1;
            end
          end else if (pci_busy_i) begin
            st    <= S_MSTR;
            ack_q <= 1'b0;
          end
        end
        S_MSTR: begin
          if (wake_cond) pend <= 1'b1;
          if (!pci_busy_i) begin
            if (pend || wake_cond) begin
              if (refresh_busy_i) begin
                st   <= S_RHOLD;
                rcnt <= '0;
              end else begin
                st     <= S_IDLE;
                wake_q <= 1'b1;
              end
            end else begin
              st    <= S_SUSP;
              ack_q <= 1'b1;
            end
          end
        end
        S_RHOLD: begin
          rcnt <= rcnt + 1'b1;
          if (!refresh_busy_i || rcnt == CW'(REF_HOLD_MAX - 1)) begin
            st     <= S_IDLE;
            ack_q  <= 1'b0;
            wake_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module halt_suspend_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_cyc_done_i,
  input logic pci_busy_i,
  input logic refresh_busy_i,
  input logic intr_i,
  input logic intr_mask_i,
  input logic smi_n_i,
  input logic sus_ack_n_o,
  input logic halt_cyc_req_o,
  input logic wake_o
);
  logic wk;
  assign wk = (intr_i & ~intr_mask_i) | ~smi_n_i;

  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cyc_req_o && !halt_cyc_done_i |=> halt_cyc_req_o);

  p_no_ack_under_pci_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sus_ack_n_o) |-> !$past(pci_busy_i));

  p_master_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sus_ack_n_o && pci_busy_i && !refresh_busy_i |=> sus_ack_n_o);

  p_fast_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sus_ack_n_o && wk && !refresh_busy_i |=> sus_ack_n_o && wake_o);

  p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  p_wake_with_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sus_ack_n_o);
endmodule

bind halt_suspend_ctl halt_suspend_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_cyc_done_i(halt_cyc_done_i),
  .pci_busy_i(pci_busy_i), .refresh_busy_i(refresh_busy_i),
  .intr_i(intr_i), .intr_mask_i(intr_mask_i), .smi_n_i(smi_n_i),
  .sus_ack_n_o(sus_ack_n_o), .halt_cyc_req_o(halt_cyc_req_o), .wake_o(wake_o)
);

// File: tb/sim_halt_suspend_ctl.sv
module sim_halt_suspend_ctl;
  localparam int HOLD = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt = 0, en = 0, done = 0, pci = 0, rfr = 0, intr = 0, msk = 0, smi_n = 1;
  logic ack_n, req, wk;
  int checks = 0, fails = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  halt_suspend_ctl #(.REF_HOLD_MAX(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_strobe_i(halt), .sus_en_i(en),
    .halt_cyc_done_i(done), .pci_busy_i(pci), .refresh_busy_i(rfr),
    .intr_i(intr), .intr_mask_i(msk), .smi_n_i(smi_n),
    .sus_ack_n_o(ack_n), .halt_cyc_req_o(req), .wake_o(wk));

  // {halt,en,done,pci,rfr,intr,msk,smi_n, exp ack_n,req,wake}
  localparam logic [10:0] VEC [11] = '{
    11'b0000_0001_100,
    11'b1100_0001_110,
    11'b0100_0001_110,
    11'b0110_0001_100,
    11'b0100_0001_000,
    11'b0100_0111_000,
    11'b0101_0001_100,
    11'b0101_0001_100,
    11'b0100_0001_000,
    11'b0100_0101_101,
    11'b0000_0001_100
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic a, input logic r, input logic w,
                     input logic ea, input logic er, input logic ew);
    checks++;
    if (a !== ea || r !== er || w !== ew) begin
      fails++;
      $display("FAIL %s: ack_n/req/wake = %b%b%b expected %b%b%b", tag, a, r, w, ea, er, ew);
    end
  endtask

  task automatic enter_susp();
    halt = 1; en = 1; step(); halt = 0;
    done = 1; step(); done = 0;
    step();
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 in reset", ack_n, req, wk, 1, 0, 0);
    rst_n = 1; step();
    chk("R1 after reset", ack_n, req, wk, 1, 0, 0);

    // main flow: halt, halt cycle, suspend, masked intr (R6), PCI window (R5), wake (R8)
    for (int i = 0; i < 11; i++) begin
      {halt, en, done, pci, rfr, intr, msk, smi_n} = VEC[i][10:3];
      step();
      chk($sformatf("R2/R3/R5/R6/R8 vector %0d", i), ack_n, req, wk,
          VEC[i][2], VEC[i][1], VEC[i][0]);
    end
    {halt, en, done, pci, rfr, intr, msk, smi_n} = 8'b0000_0001;

    // R2: disabled halt ignored
    halt = 1; en = 0; step(); halt = 0;
    chk("R2 disabled halt", ack_n, req, wk, 1, 0, 0);
    step();
    chk("R2 disabled halt later", ack_n, req, wk, 1, 0, 0);

    // R4: PCI busy at halt postpones acknowledge
    pci = 1; halt = 1; en = 1; step(); halt = 0;
    done = 1; step(); done = 0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R4 postponed", ack_n, req, wk, 1, 0, 0);
    end
    pci = 0; step();
    chk("R4 asserted after PCI", ack_n, req, wk, 0, 0, 0);
    // R6: SMI wakes even with mask set
    msk = 1; smi_n = 0; step(); smi_n = 1; msk = 0;
    chk("R6 smi wake", ack_n, req, wk, 1, 0, 1);
    step();
    chk("R8 pulse single", ack_n, req, wk, 1, 0, 0);

    // R7: refresh holds release until it ends
    enter_susp();
    chk("R3 suspended", ack_n, req, wk, 0, 0, 0);
    rfr = 1; intr = 1; step(); intr = 0;
    chk("R7 held by refresh", ack_n, req, wk, 0, 0, 0);
    step(); step();
    chk("R7 still held", ack_n, req, wk, 0, 0, 0);
    rfr = 0; step();
    chk("R7 released after refresh", ack_n, req, wk, 1, 0, 1);
    step();

    // R7: hold-back limit
    enter_susp();
    rfr = 1; smi_n = 0; step(); smi_n = 1;
    for (int k = 0; k < HOLD - 1; k++) step();
    chk("R7 bound not yet", ack_n, req, wk, 0, 0, 0);
    step();
    chk("R7 bound reached", ack_n, req, wk, 1, 0, 1);
    rfr = 0; step();

    // R9: wake latched during PCI window
    enter_susp();
    pci = 1; step();
    chk("R5 window open", ack_n, req, wk, 1, 0, 0);
    intr = 1; step(); intr = 0; step();
    chk("R9 latched, window still open", ack_n, req, wk, 1, 0, 0);
    pci = 0; step();
    chk("R9 exit at window end", ack_n, req, wk, 1, 0, 1);
    step();

    // R9: wake during halt cycle latched
    halt = 1; en = 1; step(); halt = 0;
    smi_n = 0; step(); smi_n = 1;
    chk("R9 halt cycle pending", ack_n, req, wk, 1, 1, 0);
    done = 1; step(); done = 0;
    step();
    chk("R9 suspend reached", ack_n, req, wk, 0, 0, 0);
    step();
    chk("R9 leaves at once", ack_n, req, wk, 1, 0, 1);
    step();

    // R1: reset while suspended
    enter_susp();
    rst_n = 0; #1;
    chk("R1 reset mid-suspend", ack_n, req, wk, 1, 0, 0);
    step(); rst_n = 1; step();
    chk("R1 idle after reset", ack_n, req, wk, 1, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule